// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C master read and write a bank of 8-bit configuration registers inside the chip. SCL and SDA come in from open-drain pads and are sampled by a system clock that runs much faster than SCL. The block recognises START, repeated START and STOP, and answers only to one fixed 7-bit device address. It pulls SDA low through an output-enable pin and never drives it high.

A write transaction carries the device address with R/W low. The first data byte after it sets an internal register pointer. Each later byte is stored at the pointer, and the pointer then steps forward by one. A read transaction starts sending at the current pointer and keeps going through consecutive registers for as long as the master acknowledges each byte.

The usual way to read a chosen register is to write only the pointer byte, issue a repeated START, and then read. The pointer keeps its value across the repeated START, so the read begins at the register just selected.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits, sent MSB first, equal 0010000. The eighth bit is R/W: 0 selects write and 1 selects read, giving 0x20 and 0x21 on the wire.
- R2: When the address does not match, the block gives no ACK. It leaves SDA released for the rest of the transaction, and the registers and the pointer stay unchanged.
- R3: In write mode the block holds SDA low for the whole of the 9th SCL pulse after every byte it receives, including the address byte.
- R4: The first byte written after the address loads the register pointer. Each further byte is stored at the pointer, and the pointer then increments by one.
- R5: In read mode the block sends the register at the pointer MSB first and increments the pointer for each byte sent. It sends the next register each time the master pulls SDA low on the 9th pulse.
- R6: When the master leaves SDA high on the 9th pulse (NACK), the block releases SDA and drives nothing more until the next START.
- R7: A repeated START returns the block to address reception with the bit count cleared. The register pointer keeps its value.
- R8: The register pointer is 8 bits wide and steps from 0xFF to 0x00, so a burst continues across the wrap.
- R9: SDA driven by the block changes only while SCL is low. START is an SDA fall and STOP is an SDA rise, each while SCL is high.
- R10: After reset every register reads 0x00, the pointer is 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level sampled from the pad |
| sda_in | input | 1 | SDA level sampled from the pad |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain output enable) |

## Verification
The assertions rely on a well-behaved master. It changes SDA only while SCL is low, except when it makes a START or a STOP. It never issues a START or a STOP while the slave is pulling SDA low, which means it NACKs the last byte of every read. Each SCL phase also lasts many system clocks, so the two-flop synchroniser has settled before the next edge.

The bit-banged master in the bench keeps to these rules. It uses fixed quarter-period delays, moves SDA only in the low phase, and always ends a read with a NACK before a STOP or a repeated START. The transaction mix, the lengths, the pointers and the data are drawn at random, and fixed cases for reset and the pointer wrap are added to them.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h10,
  parameter int         PTR_W    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull
);
  localparam int NREGS = 1 << PTR_W;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WRITE, ST_READ} st_t;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q    <= scl_sync[1];
      sda_q    <= sda_sync[1];
    end

  assign scl_s = scl_sync[1];
  assign sda_s = sda_sync[1];

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  st_t              st;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg, txreg;
  logic             ack_phase, rw_bit, ptr_pending, master_ack;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       regs [NREGS];
  logic [7:0]       rd_data;

  logic byte_done, addr_hit, wr_en, ptr_ld, rd_load;
  assign byte_done = scl_fall & (bitcnt == 4'd8) & ~ack_phase;
  assign addr_hit  = (shreg[7:1] == DEV_ADDR);
  assign wr_en     = byte_done & (st == ST_WRITE) & ~ptr_pending;
  assign ptr_ld    = byte_done & (st == ST_WRITE) & ptr_pending;
  assign rd_load   = scl_fall & ack_phase & ~start_c & ~stop_c &
                     (((st == ST_ADDR) & rw_bit) | ((st == ST_READ) & master_ack));
  assign rd_data   = regs[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st          <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      txreg       <= '0;
      ack_phase   <= 1'b0;
      rw_bit      <= 1'b0;
      ptr_pending <= 1'b0;
      master_ack  <= 1'b0;
      sda_pull    <= 1'b0;
    end else if (start_c) begin
      st        <= ST_ADDR;
      bitcnt    <= '0;
      ack_phase <= 1'b0;
      sda_pull  <= 1'b0;
    end else if (stop_c) begin
      st        <= ST_IDLE;
      ack_phase <= 1'b0;
      sda_pull  <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (ack_phase) begin
          master_ack <= ~sda_s;
        end
      end
      if (scl_fall) begin
        if (byte_done) begin
          case (st)
            ST_ADDR:
              if (addr_hit) begin
                ack_phase <= 1'b1;
                sda_pull  <= 1'b1;
                rw_bit    <= shreg[0];
              end else begin
                st <= ST_IDLE;
              end
            ST_WRITE: begin
              ack_phase   <= 1'b1;
              sda_pull    <= 1'b1;
              ptr_pending <= 1'b0;
            end
            default: begin
              ack_phase  <= 1'b1;
              sda_pull   <= 1'b0;
              master_ack <= 1'b0;
            end
          endcase
        end else if (ack_phase) begin
          ack_phase <= 1'b0;
          bitcnt    <= '0;
          sda_pull  <= 1'b0;
          if (st == ST_ADDR) begin
            st          <= rw_bit ? ST_READ : ST_WRITE;
            ptr_pending <= ~rw_bit;
          end
          if (st == ST_READ && !master_ack) st <= ST_IDLE;
          if (rd_load) begin
            txreg    <= {rd_data[6:0], 1'b0};
            sda_pull <= ~rd_data[7];
          end
        end else if (st == ST_READ) begin
          sda_pull <= ~txreg[7];
          txreg    <= {txreg[6:0], 1'b0};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                ptr <= '0;
    else if (ptr_ld)           ptr <= PTR_W'(shreg);
    else if (wr_en || rd_load) ptr <= ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[ptr] <= shreg;
    end

  assert_sda_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull);

  assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_phase && st != ST_READ) |-> sda_pull);

  assert_master_slot_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_phase && st == ST_READ) |-> !sda_pull);

  assert_write_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == PTR_W'($past(ptr) + 1'b1));

  assert_read_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> ptr == PTR_W'($past(ptr) + 1'b1));

  assert_restart_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == ST_ADDR) && (bitcnt == 4'd0) && (ptr == $past(ptr)));

  assert_bit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);
endmodule

// File: tb/i2c_reg_slave_test.sv
`timescale 1ns/1ps
module i2c_reg_slave_test;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  i2c_reg_slave uut (.clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_pull(sda_pull));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] model [256];
  logic [7:0] ptr_model = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); a1 = !sda_line; wq(); a2 = !sda_line;
    scl = 1'b0; wq();
    ack = a1 & a2;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); s1 = sda_line; wq(); s2 = sda_line;
      scl = 1'b0; wq();
      check(s1 == s2, "R9", int'(s2), int'(s1));
      b[i] = s1;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic write_burst(input logic [7:0] p, input int n, input string tag);
    bit a;
    logic [7:0] d;
    i2c_start();
    send_byte(8'h20, a); check(a, "R1", int'(a), 1);
    send_byte(p, a);     check(a, "R3", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, a); check(a, "R3", int'(a), 1);
      model[8'(p + i)] = d;
    end
    i2c_stop();
    ptr_model = 8'(p + n);
  endtask

  task automatic read_burst(input logic [7:0] p, input int n, input bit set_ptr, input string tag);
    bit a;
    logic [7:0] d;
    logic [7:0] q;
    q = set_ptr ? p : ptr_model;
    if (set_ptr) begin
      i2c_start();
      send_byte(8'h20, a); check(a, "R1", int'(a), 1);
      send_byte(p, a);     check(a, "R4", int'(a), 1);
    end
    i2c_start();
    send_byte(8'h21, a); check(a, set_ptr ? "R7" : "R1", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check(d == model[8'(q + i)], tag, int'(d), int'(model[8'(q + i)]));
    end
    check(sda_line == 1'b1, "R6", int'(sda_line), 1);
    scl = 1'b1; wq(); check(sda_line == 1'b1, "R6", int'(sda_line), 1); wq(); scl = 1'b0; wq();
    i2c_stop();
    ptr_model = 8'(q + n);
  endtask

  task automatic wrong_addr();
    bit a;
    logic [6:0] bad;
    bad = 7'($urandom);
    if (bad == 7'h10) bad = 7'h11;
    i2c_start();
    send_byte({bad, 1'($urandom)}, a); check(!a, "R2", int'(a), 0);
    for (int i = 0; i < 2; i++) begin
      send_byte(8'($urandom), a); check(!a, "R2", int'(a), 0);
    end
    i2c_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all) actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (10) @(negedge clk);
    check(sda_pull == 1'b0, "R10", int'(sda_pull), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(sda_line == 1'b1, "R10", int'(sda_line), 1);
    read_burst(8'h00, 3, 1'b0, "R10");

    write_burst(8'h10, 4, "R4");
    read_burst(8'h10, 4, 1'b1, "R5");
    write_burst(8'hFE, 4, "R8");
    read_burst(8'hFE, 4, 1'b1, "R8");
    wrong_addr();
    read_burst(8'hFE, 4, 1'b1, "R2");
    read_burst(8'h00, 2, 1'b0, "R7");

    for (int t = 0; t < 20; t++) begin
      case ($urandom % 4)
        0: write_burst(8'($urandom), 1 + int'($urandom % 5), "R4");
        1: read_burst(8'($urandom), 1 + int'($urandom % 5), 1'b1, "R5");
        2: wrong_addr();
        default: read_burst(8'h00, 1 + int'($urandom % 3), 1'b0, "R5");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule